// File: doc/BRIEF.md
# Hitless Reference Phase Corrector

This block sits between a reference selector and a digital phase-locked loop. It accepts the currently selected timing reference and the loop's feedback signal, and it presents the loop with a "virtual" reference: a one-cycle pulse that is a delayed copy of every falling edge of the selected reference. The delay comes from a programmable delay stage whose value is measured, not configured. When the selected reference is swapped and its phase jumps, the loop therefore sees no phase step.

A controlling state machine raises the corrector enable around a reference switch. While enable is high, the block times the gap, in master-clock cycles, from the next reference falling edge to the next feedback falling edge. It stores that count as the new delay. This re-aligns the virtual reference with the feedback the loop already tracks. Only one measurement is taken per assertion of enable. An active-low clear, once held low long enough, returns the delay to zero, so the virtual reference again follows the input phase directly.

All inputs are level signals sampled on the master clock. The only output is a single-cycle pulse. It carries no data and takes no back-pressure, so there is no valid/ready pair: the pulse is always accepted by the loop.

Top module: `ref_phase_corrector`

## Requirements
- R1: After reset the output pulse is low and the stored delay is zero. A reference falling edge driven low just before clock edge k produces the output pulse in the cycle after edge k+1, i.e. a latency of 2 cycles.
- R2: Only falling edges of the reference act. A rising edge of the reference produces no output pulse.
- R3: Each acted-on reference edge yields exactly one output pulse, high for exactly one clock cycle.
- R4: With a stored delay of D cycles, every reference falling edge yields its output pulse D+2 cycles after the input fell. The delay stays in force for all later edges.
- R5: While enable is high and no measurement has been taken yet, a reference falling edge followed N cycles later by a feedback falling edge stores N as the delay. N saturates at 65535 on a 16-bit delay.
- R6: While enable is low, reference and feedback edges leave the stored delay unchanged.
- R7: After one measurement, further edge pairs are ignored until enable has gone low and high again.
- R8: Holding the clear input low for CLR_CYCLES consecutive cycles (30 by default, 300 ns at 100 MHz) sets the delay to zero. A shorter low pulse has no effect.
- R9: A reference and a feedback falling edge seen in the same cycle while measuring store a delay of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_n | input | 1 | Active-low delay clear; must stay low CLR_CYCLES cycles |
| corr_en | input | 1 | Corrector enable from the control state machine |
| ref_in | input | 1 | Selected timing reference; falling edge active |
| fb_in | input | 1 | Loop feedback signal; falling edge active |
| vref_o | output | 1 | Virtual reference, one-cycle pulse per reference edge |

## Verification
The checks assume that successive reference falling edges are spaced further apart than the stored delay plus two cycles. Under that assumption a countdown is never restarted before it expires, and two output pulses are never adjacent. They also assume that reference and feedback levels are held for at least two cycles, so each edge is seen once. The bench drives edges only on falling clock edges and spaces reference edges by at least thirty cycles, well beyond any delay it programs. It measures the output latency as its only view of the stored delay.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  localparam int unsigned DLY_W_DEF = 16;

  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_COUNT = 2'd1,
    M_HOLD  = 2'd2
  } meas_state_t;
endpackage

// File: rtl/rpc_fall_det.sv
module rpc_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic fall_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= sig_i;
      s2_q <= s1_q;
    end
  end

  assign fall_o = s2_q & ~s1_q;
endmodule

// File: rtl/rpc_clr_filter.sv
module rpc_clr_filter #(
  parameter int unsigned CLR_CYCLES = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n,
  output logic fire_o
);
  localparam int unsigned CW = $clog2(CLR_CYCLES + 1);
  localparam logic [CW-1:0] FIRE_AT = CW'(CLR_CYCLES - 1);
  localparam logic [CW-1:0] TOP_AT  = CW'(CLR_CYCLES);

  logic          clr_s_q;
  logic [CW-1:0] low_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_s_q   <= 1'b1;
      low_cnt_q <= '0;
    end else begin
      clr_s_q <= clr_n;
      if (clr_s_q)
        low_cnt_q <= '0;
      else if (low_cnt_q != TOP_AT)
        low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  assign fire_o = !clr_s_q && (low_cnt_q == FIRE_AT);
endmodule

// File: rtl/rpc_phase_meas.sv
module rpc_phase_meas
  import rpc_pkg::*;
#(
  parameter int unsigned DLY_W = DLY_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             ref_fall_i,
  input  logic             fb_fall_i,
  input  logic             clr_i,
  output logic [DLY_W-1:0] delay_o,
  output logic             busy_o
);
  localparam logic [DLY_W-1:0] SAT = {DLY_W{1'b1}};

  meas_state_t      state_q;
  logic [DLY_W-1:0] mcnt_q;
  logic [DLY_W-1:0] delay_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= M_IDLE;
      mcnt_q  <= '0;
      delay_q <= '0;
    end else if (clr_i) begin
      state_q <= M_HOLD;
      mcnt_q  <= '0;
      delay_q <= '0;
    end else begin
      unique case (state_q)
        M_IDLE: begin
          if (en_i && ref_fall_i) begin
            if (fb_fall_i) begin
              delay_q <= '0;
              state_q <= M_HOLD;
            end else begin
              mcnt_q  <= {{(DLY_W-1){1'b0}}, 1'b1};
              state_q <= M_COUNT;
            end
          end
        end
        M_COUNT: begin
          if (!en_i) begin
            state_q <= M_IDLE;
          end else if (fb_fall_i) begin
            delay_q <= mcnt_q;
            state_q <= M_HOLD;
          end else if (mcnt_q != SAT) begin
            mcnt_q <= mcnt_q + 1'b1;
          end
        end
        M_HOLD: begin
          if (!en_i) state_q <= M_IDLE;
        end
        default: state_q <= M_IDLE;
      endcase
    end
  end

  assign delay_o = delay_q;
  assign busy_o  = (state_q == M_COUNT);
endmodule

// File: rtl/rpc_delay_line.sv
module rpc_delay_line #(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             pulse_o
);
  localparam logic [DLY_W-1:0] ONE = {{(DLY_W-1){1'b0}}, 1'b1};

  logic             run_q;
  logic [DLY_W-1:0] cnt_q;
  logic             pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (trig_i) begin
        if (delay_i == '0) begin
          pulse_q <= 1'b1;
          run_q   <= 1'b0;
        end else begin
          cnt_q <= delay_i;
          run_q <= 1'b1;
        end
      end else if (run_q) begin
        if (cnt_q == ONE) begin
          pulse_q <= 1'b1;
          run_q   <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/ref_phase_corrector.sv
module ref_phase_corrector
  import rpc_pkg::*;
#(
  parameter int unsigned DLY_W      = DLY_W_DEF,
  parameter int unsigned CLR_CYCLES = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n,
  input  logic corr_en,
  input  logic ref_in,
  input  logic fb_in,
  output logic vref_o
);
  localparam int unsigned NSRC = 2;

  logic [NSRC-1:0]  src_lvl;
  logic [NSRC-1:0]  src_fall;
  logic             ref_fall;
  logic             fb_fall;
  logic             clr_fire;
  logic             meas_busy;
  logic [DLY_W-1:0] delay_q;

  assign src_lvl = {fb_in, ref_in};

  for (genvar g = 0; g < NSRC; g++) begin : g_edge
    rpc_fall_det u_fd (
      .clk   (clk),
      .rst_n (rst_n),
      .sig_i (src_lvl[g]),
      .fall_o(src_fall[g])
    );
  end

  assign ref_fall = src_fall[0];
  assign fb_fall  = src_fall[1];

  rpc_clr_filter #(.CLR_CYCLES(CLR_CYCLES)) u_clr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_n (clr_n),
    .fire_o(clr_fire)
  );

  rpc_phase_meas #(.DLY_W(DLY_W)) u_meas (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (corr_en),
    .ref_fall_i(ref_fall),
    .fb_fall_i (fb_fall),
    .clr_i     (clr_fire),
    .delay_o   (delay_q),
    .busy_o    (meas_busy)
  );

  rpc_delay_line #(.DLY_W(DLY_W)) u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (ref_fall),
    .delay_i(delay_q),
    .pulse_o(vref_o)
  );
endmodule

// File: rtl/rpc_checker.sv
module rpc_checker #(
  parameter int unsigned DLY_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             corr_en,
  input logic             vref_o,
  input logic             ref_fall,
  input logic             fb_fall,
  input logic             clr_fire,
  input logic             meas_busy,
  input logic [DLY_W-1:0] delay_q
);
  // R1: output idle on the first cycle out of reset
  a_r1_reset_idle: assert property (@(posedge clk)
    $rose(rst_n) |-> !vref_o);

  // R3: pulse is a single cycle wide
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vref_o |=> !vref_o);

  // R5, R6, R9: delay moves only on a measurement or a clear
  a_r5_delay_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(delay_q) |-> ($past(clr_fire) || $past(meas_busy && fb_fall)
                           || $past(corr_en && ref_fall && fb_fall)));

  // R6: no measurement runs while enable is low
  a_r6_no_count_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !corr_en |=> !meas_busy);

  // R8: a qualified clear leaves zero delay
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> (delay_q == '0));
endmodule

bind ref_phase_corrector rpc_checker #(.DLY_W(DLY_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .corr_en  (corr_en),
  .vref_o   (vref_o),
  .ref_fall (ref_fall),
  .fb_fall  (fb_fall),
  .clr_fire (clr_fire),
  .meas_busy(meas_busy),
  .delay_q  (delay_q)
);

// File: tb/ref_phase_corrector_tb.sv
module ref_phase_corrector_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_n = 1'b1;
  logic corr_en = 1'b0;
  logic ref_in = 1'b1;
  logic fb_in = 1'b1;
  logic vref_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ref_phase_corrector u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_n  (clr_n),
    .corr_en(corr_en),
    .ref_in (ref_in),
    .fb_in  (fb_in),
    .vref_o (vref_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one reference falling edge, return latency in cycles and pulse width
  task automatic ref_edge(input int exp_lat, input string req);
    int lat = -1;
    int width = 0;
    @(negedge clk) ref_in = 1'b0;
    for (int n = 1; n <= exp_lat + 20; n++) begin
      @(negedge clk);
      if (vref_o) begin
        if (lat < 0) lat = n;
        width++;
      end
    end
    check(lat == exp_lat, req, lat, exp_lat);
    check(width == 1, "R3", width, 1);
    @(negedge clk) ref_in = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // Reference edge, then feedback edge off cycles later; enable level given
  task automatic edge_pair(input int off, input bit en, input bit drop_en);
    @(negedge clk) corr_en = en;
    @(negedge clk);
    ref_in = 1'b0;
    if (off == 0) fb_in = 1'b0;
    for (int i = 0; i < off; i++) @(negedge clk);
    fb_in = 1'b0;
    repeat (4) @(negedge clk);
    ref_in = 1'b1;
    fb_in  = 1'b1;
    repeat (40) @(negedge clk);
    if (drop_en) corr_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(vref_o == 1'b0, "R1", vref_o, 0);
    ref_edge(2, "R1");
  endtask

  task automatic t_rising_ignored;
    int seen = 0;
    @(negedge clk) ref_in = 1'b0;
    repeat (10) @(negedge clk);
    @(negedge clk) ref_in = 1'b1;
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      if (vref_o) seen++;
    end
    check(seen == 0, "R2", seen, 0);
  endtask

  task automatic t_measure;
    edge_pair(7, 1'b1, 1'b1);
    ref_edge(9, "R5");
    ref_edge(9, "R4");
    ref_edge(9, "R4");
  endtask

  task automatic t_single_measure;
    edge_pair(12, 1'b1, 1'b0);
    ref_edge(14, "R5");
    edge_pair(3, 1'b1, 1'b1);
    ref_edge(14, "R7");
  endtask

  task automatic t_disabled;
    edge_pair(4, 1'b0, 1'b1);
    ref_edge(14, "R6");
  endtask

  task automatic t_clear;
    @(negedge clk) clr_n = 1'b0;
    repeat (10) @(negedge clk);
    clr_n = 1'b1;
    repeat (5) @(negedge clk);
    ref_edge(14, "R8");
    @(negedge clk) clr_n = 1'b0;
    repeat (40) @(negedge clk);
    clr_n = 1'b1;
    repeat (5) @(negedge clk);
    ref_edge(2, "R8");
  endtask

  task automatic t_same_cycle;
    edge_pair(5, 1'b1, 1'b1);
    ref_edge(7, "R5");
    edge_pair(0, 1'b1, 1'b1);
    ref_edge(2, "R9");
    edge_pair(1, 1'b1, 1'b1);
    ref_edge(3, "R5");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_rising_ignored();
    t_measure();
    t_single_measure();
    t_disabled();
    t_clear();
    t_same_cycle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule